// File: doc/BRIEF.md
# Alternating Read-Write Cycle Controller

This block decides, at each rising clock edge, whether a synchronous memory performs a read, a write or no operation. Three active-low select inputs take part: a run select, which also marks where a new run of accesses begins, and a set of bank selects. An access happens only when all of them are asserted. A run-start input picks the direction of the first access in a run. It is low for write and high for read.

The block samples the run-start input only once per run: on the first access after the run select has been released. From then on the direction flips on every access, and the run-start input is ignored. When only a bank select is released, no access takes place, but the flip pattern carries on where it stopped. The echo-clock enable follows the bank selects alone. Releasing only the run select leaves it on.

The outputs are registered. Each access shows up as a one-cycle strobe after the clock edge that sampled it, together with its direction.

Top module: `rw_alternator`

## Requirements
- R1: `op_valid` is 1 in the cycle after an edge at which `run_sel_n` and every bit of `bank_sel_n` were 0. Otherwise it is 0.
- R2: The first access after reset, or after any edge that sampled `run_sel_n`=1, takes its direction from `wr_start_n`. A value of 0 gives a write (`op_is_write`=1) and a value of 1 gives a read (`op_is_write`=0).
- R3: Every later access in the same run has the opposite direction to the previous access, whatever the value of `wr_start_n`.
- R4: An edge with `run_sel_n`=0 and any `bank_sel_n` bit at 1 performs no access and does not restart the run. The next access still has the opposite direction to the last one.
- R5: Any number of consecutive no-access cycles between accesses leaves R2–R4 unchanged.
- R6: `echo_en` is 0 in the cycle after an edge at which any `bank_sel_n` bit was 1, and 1 after an edge at which all bits were 0. `run_sel_n` has no effect on it.
- R7: All inputs are sampled on the rising edge and all outputs are registered. `op_is_write` is 0 whenever `op_valid` is 0.
- R8: While `rst_n` is low, all outputs are 0. After reset, the block behaves as if the run select had just been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_sel_n | input | 1 | Active-low run select; releasing it restarts the run |
| bank_sel_n | input | NUM_BANK_SEL | Active-low bank selects |
| wr_start_n | input | 1 | Direction of the first access in a run (0 = write) |
| op_valid | output | 1 | One-cycle strobe per access |
| op_is_write | output | 1 | Direction of the current access (1 = write) |
| echo_en | output | 1 | Echo-clock enable |

## Verification
On every cycle, the assertions check four things:
- the strobe against the selects sampled at the previous edge;
- the echo enable against the bank selects;
- a run restart after a release of the run select;
- that each access's direction matches either the sampled run-start input or the inverse of the tracked previous direction.

Only the bench's scenarios can show whole-sequence properties. These are that alternation survives long gaps made of bank-only releases, that the run-start input truly has no effect in the middle of a run, and that all ordered pairs of input combinations give the modelled results.

// File: rtl/rwalt_pkg.sv
package rwalt_pkg;

    typedef struct packed {
        logic op_valid;
        logic op_is_write;
        logic echo_en;
    } rwalt_out_t;

    typedef struct packed {
        logic fresh;
        logic last_wr;
    } rwalt_dir_t;

endpackage

// File: rtl/rwalt_enable_decode.sv
module rwalt_enable_decode #(
    parameter int NUM_BANK_SEL = 2
) (
    input  logic                    run_sel_n,
    input  logic [NUM_BANK_SEL-1:0] bank_sel_n,
    output logic                    bank_ok,
    output logic                    active
);
    always_comb begin
        bank_ok = ~(|bank_sel_n);
        active  = bank_ok & ~run_sel_n;
    end
endmodule

// File: rtl/rwalt_dir_track.sv
module rwalt_dir_track
    import rwalt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic run_gap,
    input  logic wr_start_n,
    output logic wr_now,
    output logic fresh,
    output logic last_wr
);
    rwalt_dir_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wr_now = st_q.fresh ? ~wr_start_n : ~st_q.last_wr;
        if (active) begin
            st_d.fresh   = 1'b0;
            st_d.last_wr = wr_now;
        end else if (run_gap) begin
            st_d.fresh = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{fresh: 1'b1, last_wr: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fresh   = st_q.fresh;
    assign last_wr = st_q.last_wr;

    assert_restart_on_run_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run_gap |=> fresh);
    assert_bank_gap_keeps_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_gap && !active) |=> ($stable(fresh) && $stable(last_wr)));
endmodule

// File: rtl/rw_alternator.sv
module rw_alternator
    import rwalt_pkg::*;
#(
    parameter int NUM_BANK_SEL = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run_sel_n,
    input  logic [NUM_BANK_SEL-1:0] bank_sel_n,
    input  logic                    wr_start_n,
    output logic                    op_valid,
    output logic                    op_is_write,
    output logic                    echo_en
);
    logic bank_ok, active, wr_now, fresh, last_wr;
    rwalt_out_t out_d, out_q;

    rwalt_enable_decode #(.NUM_BANK_SEL(NUM_BANK_SEL)) u_dec (
        .run_sel_n  (run_sel_n),
        .bank_sel_n (bank_sel_n),
        .bank_ok    (bank_ok),
        .active     (active)
    );

    rwalt_dir_track u_dir (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .run_gap    (run_sel_n),
        .wr_start_n (wr_start_n),
        .wr_now     (wr_now),
        .fresh      (fresh),
        .last_wr    (last_wr)
    );

    always_comb begin
        out_d.op_valid    = active;
        out_d.op_is_write = active & wr_now;
        out_d.echo_en     = bank_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign op_valid    = out_q.op_valid;
    assign op_is_write = out_q.op_is_write;
    assign echo_en     = out_q.echo_en;

    assert_access_when_selected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_sel_n && !(|bank_sel_n)) |=> op_valid);
    assert_idle_when_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_sel_n || (|bank_sel_n)) |=> !op_valid);
    assert_first_dir_from_pin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_sel_n && !(|bank_sel_n) && fresh) |=> (op_is_write == !$past(wr_start_n)));
    assert_flip_in_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_sel_n && !(|bank_sel_n) && !fresh) |=> (op_is_write == !$past(last_wr)));
    assert_echo_follows_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (echo_en == !$past(|bank_sel_n)));
    assert_no_dir_without_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !op_is_write);
endmodule

// File: tb/rw_alternator_test.sv
module rw_alternator_test;
    localparam int NB = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_sel_n = 1'b1;
    logic [NB-1:0] bank_sel_n = '1;
    logic          wr_start_n = 1'b1;
    logic          op_valid, op_is_write, echo_en;

    int checks = 0;
    int failures = 0;
    bit m_fresh = 1'b1;
    bit m_last = 1'b0;
    bit m_bank_gap = 1'b0;
    bit finished = 1'b0;
    int unsigned lcg = 32'h1234_5678;

    always #2 clk = ~clk;

    rw_alternator #(.NUM_BANK_SEL(NB)) uut (
        .clk(clk), .rst_n(rst_n), .run_sel_n(run_sel_n), .bank_sel_n(bank_sel_n),
        .wr_start_n(wr_start_n), .op_valid(op_valid), .op_is_write(op_is_write),
        .echo_en(echo_en)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic run, input logic [NB-1:0] bank, input logic w);
        bit act;
        bit ew;
        string dtag;
        run_sel_n  = run;
        bank_sel_n = bank;
        wr_start_n = w;
        act = !run && (bank == '0);
        ew = 1'b0;
        dtag = "R7";
        if (act) begin
            if (m_fresh) begin ew = !w; dtag = "R2"; end
            else begin ew = !m_last; dtag = m_bank_gap ? "R4" : "R3"; end
            m_last = ew; m_fresh = 1'b0; m_bank_gap = 1'b0;
        end else if (run) begin
            m_fresh = 1'b1;
        end else begin
            m_bank_gap = 1'b1;
        end
        @(posedge clk);
        #1;
        check("R1", op_valid, act);
        check(dtag, op_is_write, ew);
        check("R6", echo_en, bank == '0);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R8", op_valid, 1'b0);
        check("R8", op_is_write, 1'b0);
        check("R8", echo_en, 1'b0);
        rst_n = 1'b1;
        // R8: first access after reset samples wr_start_n (write)
        step(1'b0, '0, 1'b0);
        step(1'b0, '0, 1'b0);   // R3: must be read despite w=0
        step(1'b0, '0, 1'b1);   // R3: write
        // R5: long bank-only gap keeps alternation (R4)
        for (int i = 0; i < 20; i++) step(1'b0, 2'b01, 1'b1);
        step(1'b0, '0, 1'b1);   // expect read
        // R5: long run-select gap restarts
        for (int i = 0; i < 20; i++) step(1'b1, '0, 1'b0);
        step(1'b0, '0, 1'b1);   // R2: read
        // exhaustive ordered pairs of input combinations
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                step(a[3], a[2:1], a[0]);
                step(b[3], b[2:1], b[0]);
            end
        end
        // pseudo-random run biased toward access
        for (int i = 0; i < 1500; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            step(lcg[31:30] == 2'b11, (lcg[29:27] == 3'b000) ? lcg[26:25] : 2'b00, lcg[24]);
        end
        // reset mid-run returns to R8 state
        rst_n = 1'b0;
        #1;
        check("R8", op_valid, 1'b0);
        check("R8", echo_en, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        m_fresh = 1'b1; m_bank_gap = 1'b0;
        step(1'b0, '0, 1'b1);   // R8/R2: read
        step(1'b0, '0, 1'b1);   // R3: write
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule